// File: doc/BRIEF.md
# Latched Line Alarm Status Register

This block collects sixteen raw alarm conditions from a line receiver's framing and line monitors. It holds each one in a pending latch until software has seen it, and raises one interrupt output. Each bit is one of two kinds. An event bit latches only when its condition rises. A level bit latches on every change, so both the onset and the end of a condition are reported. A mode input moves a few upper bits from the event group to the level group. A third mode hides everything except the loss-of-cell indication.

Software reaches the block through a single-cycle register bus. Reading the status register returns, for each bit, the live condition ORed with the pending latch. The read then clears every latch it returned, unless a new transition arrives in the same cycle. The result is that a fault which cleared before the read is still seen once, and a second read gives the present state. An enable register decides which pending bits may drive the interrupt. It has no effect on latching.

Top module: `line_alarm_status`

## Requirements
- R1: A read strobe at address 0x38 returns status and a read at 0x3A returns the enable register. Read data appears on `rdata_o` in the cycle after the strobe. Any other address reads zero. Writes to 0x3A load the enable register, and writes to 0x38 change nothing.
- R2: Pending bits latch whether or not they are enabled. The enable register affects only `irq_o`, and an enable write that covers an already pending bit raises `irq_o` in the next cycle.
- R3: A pending bit stays set until a status read.
- R4: For each visible bit, a status read returns the live condition OR the pending latch, then clears the pending latch. When a condition cleared before the read, the first read shows the bit as 1 and the second read shows 0.
- R5: Event bits latch only on a 0-to-1 change of their condition. A 1-to-0 change neither sets the latch nor raises `irq_o`. Bits 15 to 9 are event bits in mode 0 (`mode_i`=00 or 11).
- R6: Bits 8 to 0 are level bits in every mode. Both a rise and a fall of the condition each set the pending latch.
- R7: In mode 1 (`mode_i`=01, synchronous optical or E3/E4 framing), bits 9, 12 and 13 act as level bits. Bits 10, 11, 14 and 15 stay event bits.
- R8: In mode 2 (`mode_i`=10, parallel or external framer), only bit 8 (loss of cell) can latch or read as 1. All other bits read 0 and never interrupt.
- R9: When a qualifying transition occurs in the same cycle as a status read, that bit's pending latch stays set and `irq_o` stays high.
- R10: `irq_o` is a register equal to the OR over all bits of pending AND enable. It rises in the cycle after the input change and falls in the cycle after a clearing read.
- R11: Synchronous reset clears the pending latches, the enable register, `rdata_o` and `irq_o`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| cond_i | input | 16 | Raw alarm conditions |
| mode_i | input | 2 | Framing mode: 00 direct, 01 optical/E3-E4, 10 parallel, 11 as 00 |
| rd_en | input | 1 | Single-cycle read strobe |
| wr_en | input | 1 | Single-cycle write strobe |
| addr | input | 8 | Register address |
| wdata | input | 16 | Write data |
| rdata_o | output | 16 | Registered read data |
| irq_o | output | 1 | Registered active-high interrupt |

## Verification
The bench drives a fault that clears before it is read. A design that returned only the live value would lose that fault, and one that never cleared the latch would report it forever. Event bits get a falling edge, and a design that watched both edges would raise an extra interrupt there. Mode 1 and mode 2 are exercised for bits that change group or must be hidden. A transition that lands on the same edge as a read checks that a design clearing on read does not drop the new interrupt. Disabled bits that later become enabled check that latching does not depend on the enable.

// File: rtl/alm_pkg.sv
package alm_pkg;
  typedef enum logic [1:0] {
    ALM_MODE_DIRECT   = 2'b00,
    ALM_MODE_OPTICAL  = 2'b01,
    ALM_MODE_PARALLEL = 2'b10,
    ALM_MODE_ALT      = 2'b11
  } alm_mode_e;
endpackage

// File: rtl/alm_cond_sync.sv
module alm_cond_sync #(
  parameter int W         = 16,
  parameter int EVENT_LSB = 9
) (
  input  logic         clk,
  input  logic         rst,
  input  logic [W-1:0] cond_i,
  input  logic [W-1:0] level_mask,
  input  logic [W-1:0] vis_mask,
  output logic [W-1:0] cond_q,
  output logic [W-1:0] trans_o
);
  always_ff @(posedge clk) begin
    if (rst) cond_q <= '0;
    else     cond_q <= cond_i;
  end

  for (genvar i = 0; i < W; i++) begin : g_bit
    logic rise_w, any_w;
    assign rise_w = cond_i[i] & ~cond_q[i];
    assign any_w  = cond_i[i] ^ cond_q[i];
    if (i < EVENT_LSB) begin : g_level
      // lower group is always level-sensitive
      logic unused_lvl;
      assign unused_lvl = level_mask[i] | rise_w;
      assign trans_o[i] = vis_mask[i] & any_w;
    end else begin : g_sel
      assign trans_o[i] = vis_mask[i] & (level_mask[i] ? any_w : rise_w);
    end
  end
endmodule

// File: rtl/alm_pend_bank.sv
module alm_pend_bank #(
  parameter int W = 16
) (
  input  logic         clk,
  input  logic         rst,
  input  logic [W-1:0] set_i,
  input  logic         rd_clr_i,
  input  logic [W-1:0] vis_mask,
  output logic [W-1:0] pend_d,
  output logic [W-1:0] pend_q
);
  for (genvar i = 0; i < W; i++) begin : g_latch
    // a set on the read cycle wins over the clear
    assign pend_d[i] = vis_mask[i] & (set_i[i] | (pend_q[i] & ~rd_clr_i));
    always_ff @(posedge clk) begin
      if (rst) pend_q[i] <= 1'b0;
      else     pend_q[i] <= pend_d[i];
    end
  end
endmodule

// File: rtl/alm_reg_if.sv
module alm_reg_if #(
  parameter int          W         = 16,
  parameter int          ADDR_W    = 8,
  parameter logic [ADDR_W-1:0] STAT_ADDR = 8'h38,
  parameter logic [ADDR_W-1:0] EN_ADDR   = 8'h3A
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              rd_en,
  input  logic              wr_en,
  input  logic [ADDR_W-1:0] addr,
  input  logic [W-1:0]      wdata,
  input  logic [W-1:0]      stat_view,
  output logic [W-1:0]      en_d,
  output logic [W-1:0]      en_q,
  output logic              rd_stat,
  output logic [W-1:0]      rdata_o
);
  logic hit_stat, hit_en;
  logic [W-1:0] rd_mux;

  assign hit_stat = (addr == STAT_ADDR);
  assign hit_en   = (addr == EN_ADDR);
  assign rd_stat  = rd_en & hit_stat;
  assign en_d     = (wr_en & hit_en) ? wdata : en_q;

  always_comb begin
    rd_mux = '0;
    if (hit_stat)    rd_mux = stat_view;
    else if (hit_en) rd_mux = en_q;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      en_q    <= '0;
      rdata_o <= '0;
    end else begin
      en_q <= en_d;
      if (rd_en) rdata_o <= rd_mux;
    end
  end
endmodule

// File: rtl/alm_irq_gen.sv
module alm_irq_gen #(
  parameter int W = 16
) (
  input  logic         clk,
  input  logic         rst,
  input  logic [W-1:0] pend_d,
  input  logic [W-1:0] en_d,
  output logic         irq_o
);
  always_ff @(posedge clk) begin
    if (rst) irq_o <= 1'b0;
    else     irq_o <= |(pend_d & en_d);
  end
endmodule

// File: rtl/line_alarm_status.sv
module line_alarm_status
  import alm_pkg::*;
#(
  parameter int                W          = 16,
  parameter int                EVENT_LSB  = 9,
  parameter int                LOSS_BIT   = 8,
  parameter int                ADDR_W     = 8,
  parameter logic [ADDR_W-1:0] STAT_ADDR  = 8'h38,
  parameter logic [ADDR_W-1:0] EN_ADDR    = 8'h3A,
  parameter logic [W-1:0]      OPT_LEVEL  = 16'h3200
) (
  input  logic              clk,
  input  logic              rst,
  input  logic [W-1:0]      cond_i,
  input  logic [1:0]        mode_i,
  input  logic              rd_en,
  input  logic              wr_en,
  input  logic [ADDR_W-1:0] addr,
  input  logic [W-1:0]      wdata,
  output logic [W-1:0]      rdata_o,
  output logic              irq_o
);
  localparam logic [W-1:0] BASE_LEVEL = W'((64'd1 << EVENT_LSB) - 64'd1);
  localparam logic [W-1:0] LOSS_ONLY  = W'(64'd1 << LOSS_BIT);

  alm_mode_e     mode;
  logic [W-1:0]  level_mask, vis_mask;
  logic [W-1:0]  cond_q, trans, pend_d, pend_q, en_d, en_q, stat_view;
  logic          rd_stat;

  assign mode = alm_mode_e'(mode_i);

  always_comb begin
    level_mask = BASE_LEVEL;
    vis_mask   = '1;
    case (mode)
      ALM_MODE_OPTICAL:  level_mask = BASE_LEVEL | OPT_LEVEL;
      ALM_MODE_PARALLEL: vis_mask   = LOSS_ONLY;
      default: ;
    endcase
  end

  alm_cond_sync #(.W(W), .EVENT_LSB(EVENT_LSB)) u_sync (
    .clk(clk), .rst(rst), .cond_i(cond_i), .level_mask(level_mask),
    .vis_mask(vis_mask), .cond_q(cond_q), .trans_o(trans)
  );

  alm_pend_bank #(.W(W)) u_pend (
    .clk(clk), .rst(rst), .set_i(trans), .rd_clr_i(rd_stat),
    .vis_mask(vis_mask), .pend_d(pend_d), .pend_q(pend_q)
  );

  assign stat_view = (cond_q & vis_mask) | pend_q;

  alm_reg_if #(.W(W), .ADDR_W(ADDR_W), .STAT_ADDR(STAT_ADDR), .EN_ADDR(EN_ADDR)) u_regs (
    .clk(clk), .rst(rst), .rd_en(rd_en), .wr_en(wr_en), .addr(addr),
    .wdata(wdata), .stat_view(stat_view), .en_d(en_d), .en_q(en_q),
    .rd_stat(rd_stat), .rdata_o(rdata_o)
  );

  alm_irq_gen #(.W(W)) u_irq (
    .clk(clk), .rst(rst), .pend_d(pend_d), .en_d(en_d), .irq_o(irq_o)
  );
endmodule

// File: rtl/alm_status_checker.sv
module alm_status_checker #(
  parameter int W        = 16,
  parameter int LOSS_BIT = 8
) (
  input logic         clk,
  input logic         rst,
  input logic [W-1:0] cond_i,
  input logic [1:0]   mode_i,
  input logic [W-1:0] cond_q,
  input logic [W-1:0] pend_q,
  input logic [W-1:0] en_q,
  input logic         rd_stat,
  input logic [W-1:0] rdata_o,
  input logic         irq_o
);
  localparam logic [W-1:0] LOSS_ONLY = W'(64'd1 << LOSS_BIT);

  AST_RESET_QUIET: assert property (@(posedge clk)
    $past(rst) |-> (!irq_o && pend_q == '0 && en_q == '0)); // R11

  AST_PEND_HOLD: assert property (@(posedge clk) disable iff (rst)
    (!rd_stat && $stable(mode_i)) |=> ((pend_q & $past(pend_q)) == $past(pend_q))); // R3

  AST_READ_SHOWS_PEND: assert property (@(posedge clk) disable iff (rst)
    rd_stat |=> ((rdata_o & $past(pend_q)) == $past(pend_q))); // R4

  AST_EN_GATES_IRQ: assert property (@(posedge clk) disable iff (rst)
    (en_q == '0) |-> !irq_o); // R2

  AST_PARALLEL_LOSS_ONLY: assert property (@(posedge clk) disable iff (rst)
    (mode_i == 2'b10) |=> ((pend_q & ~LOSS_ONLY) == '0)); // R8

  AST_TOP_EVENT_RISE: assert property (@(posedge clk) disable iff (rst)
    $rose(pend_q[W-1]) |-> $past(cond_i[W-1] && !cond_q[W-1])); // R5
endmodule

bind line_alarm_status alm_status_checker #(.W(W), .LOSS_BIT(LOSS_BIT)) u_chk (
  .clk(clk), .rst(rst), .cond_i(cond_i), .mode_i(mode_i), .cond_q(cond_q),
  .pend_q(pend_q), .en_q(en_q), .rd_stat(rd_stat), .rdata_o(rdata_o), .irq_o(irq_o)
);

// File: tb/line_alarm_status_bench.sv
`timescale 1ns/1ps
module line_alarm_status_bench;
  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic [15:0] cond_i = '0;
  logic [1:0]  mode_i = '0;
  logic        rd_en = 1'b0, wr_en = 1'b0;
  logic [7:0]  addr = 8'h38;
  logic [15:0] wdata = '0;
  logic [15:0] rdata_o;
  logic        irq_o;
  int checks = 0, failures = 0;
  bit done = 0;

  always #2 clk = ~clk;

  line_alarm_status u_line_alarm_status (
    .clk(clk), .rst(rst), .cond_i(cond_i), .mode_i(mode_i), .rd_en(rd_en),
    .wr_en(wr_en), .addr(addr), .wdata(wdata), .rdata_o(rdata_o), .irq_o(irq_o)
  );

  // {cond, mode, read, expected rdata, expected irq}
  localparam int NSTEP = 30;
  localparam logic [35:0] TBL [NSTEP] = '{
    {16'h0000, 2'd0, 1'b0, 16'h0000, 1'b0},
    {16'h0001, 2'd0, 1'b0, 16'h0000, 1'b1}, // R6 rise
    {16'h0001, 2'd0, 1'b1, 16'h0001, 1'b0},
    {16'h0000, 2'd0, 1'b0, 16'h0000, 1'b1}, // R6 fall
    {16'h0000, 2'd0, 1'b1, 16'h0001, 1'b0}, // R4 first read
    {16'h0000, 2'd0, 1'b1, 16'h0000, 1'b0}, // R4 second read
    {16'h0200, 2'd0, 1'b0, 16'h0000, 1'b1}, // R5 rise
    {16'h0000, 2'd0, 1'b0, 16'h0000, 1'b1}, // R3 hold
    {16'h0000, 2'd0, 1'b1, 16'h0200, 1'b0},
    {16'h0000, 2'd0, 1'b1, 16'h0000, 1'b0},
    {16'h0200, 2'd0, 1'b0, 16'h0000, 1'b1},
    {16'h0200, 2'd0, 1'b1, 16'h0200, 1'b0},
    {16'h0000, 2'd0, 1'b0, 16'h0000, 1'b0}, // R5 fall quiet
    {16'h0000, 2'd0, 1'b1, 16'h0000, 1'b0},
    {16'h0000, 2'd1, 1'b0, 16'h0000, 1'b0},
    {16'h2000, 2'd1, 1'b0, 16'h0000, 1'b1}, // R7 bit13 rise
    {16'h2000, 2'd1, 1'b1, 16'h2000, 1'b0},
    {16'h0000, 2'd1, 1'b0, 16'h0000, 1'b1}, // R7 bit13 fall
    {16'h0000, 2'd1, 1'b1, 16'h2000, 1'b0},
    {16'h0000, 2'd1, 1'b1, 16'h0000, 1'b0},
    {16'h8000, 2'd1, 1'b0, 16'h0000, 1'b1}, // R7 bit15 event
    {16'h0000, 2'd1, 1'b0, 16'h0000, 1'b1},
    {16'h0000, 2'd1, 1'b1, 16'h8000, 1'b0},
    {16'h0000, 2'd1, 1'b1, 16'h0000, 1'b0},
    {16'h0000, 2'd2, 1'b0, 16'h0000, 1'b0},
    {16'h0101, 2'd2, 1'b0, 16'h0000, 1'b1}, // R8 loss bit
    {16'h0101, 2'd2, 1'b1, 16'h0100, 1'b0}, // R8 bit0 hidden
    {16'h0001, 2'd2, 1'b0, 16'h0000, 1'b1},
    {16'h0001, 2'd2, 1'b1, 16'h0100, 1'b0},
    {16'h0001, 2'd2, 1'b1, 16'h0000, 1'b0}
  };

  task automatic chk(input string req, input logic [15:0] act, input logic [15:0] exp);
    checks++;
    if (act !== exp) begin
      failures++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic rd(input logic [7:0] a);
    @(negedge clk); rd_en = 1'b1; addr = a;
    @(negedge clk); rd_en = 1'b0;
  endtask

  task automatic wr(input logic [7:0] a, input logic [15:0] d);
    @(negedge clk); wr_en = 1'b1; addr = a; wdata = d;
    @(negedge clk); wr_en = 1'b0;
  endtask

  task automatic step(input logic [15:0] c);
    @(negedge clk); cond_i = c;
    @(negedge clk);
  endtask

  initial begin
    #800000;
    if (!done) begin
      checks++; failures++;
      $display("FAIL watchdog expired");
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

  initial begin
    repeat (4) @(negedge clk);
    rst = 1'b0;
    chk("R11 irq after reset", {15'd0, irq_o}, 16'h0000);
    chk("R11 rdata after reset", rdata_o, 16'h0000);
    rd(8'h3A); chk("R11 enable cleared", rdata_o, 16'h0000);
    rd(8'h38); chk("R11 status cleared", rdata_o, 16'h0000);
    wr(8'h3A, 16'hFFFF);
    rd(8'h3A); chk("R1 enable readback", rdata_o, 16'hFFFF);

    for (int i = 0; i < NSTEP; i++) begin
      @(negedge clk);
      cond_i = TBL[i][35:20]; mode_i = TBL[i][19:18];
      rd_en = TBL[i][17]; addr = 8'h38;
      @(negedge clk);
      rd_en = 1'b0;
      if (TBL[i][17]) chk($sformatf("R4 table read step %0d", i), rdata_o, TBL[i][16:1]);
      chk($sformatf("R10 table irq step %0d", i), {15'd0, irq_o}, {15'd0, TBL[i][0]});
    end

    // back to mode 0 and drain
    @(negedge clk); mode_i = 2'd0; cond_i = '0;
    rd(8'h38); rd(8'h38);
    chk("R4 drained", rdata_o, 16'h0000);

    // R2: latching without enable, then enabling raises irq
    wr(8'h3A, 16'h0000);
    step(16'h0010);
    chk("R2 disabled no irq", {15'd0, irq_o}, 16'h0000);
    wr(8'h3A, 16'h0010);
    chk("R2 late enable raises irq", {15'd0, irq_o}, 16'h0001);
    rd(8'h38);
    chk("R2 latched while disabled", rdata_o, 16'h0010);
    chk("R10 read drops irq", {15'd0, irq_o}, 16'h0000);
    step(16'h0000);
    rd(8'h38); rd(8'h38);
    wr(8'h3A, 16'hFFFF);

    // R9: transition on the same edge as a read
    step(16'h0002);
    @(negedge clk); cond_i = 16'h0003; rd_en = 1'b1; addr = 8'h38;
    @(negedge clk); rd_en = 1'b0;
    chk("R9 read value", rdata_o, 16'h0002);
    chk("R9 irq kept", {15'd0, irq_o}, 16'h0001);
    rd(8'h38);
    chk("R9 new bit latched", rdata_o, 16'h0003);
    chk("R9 irq cleared", {15'd0, irq_o}, 16'h0000);
    step(16'h0000);
    rd(8'h38); rd(8'h38);

    // R1: write to status ignored, unmapped read zero
    wr(8'h38, 16'hFFFF);
    rd(8'h38);
    chk("R1 status write ignored", rdata_o, 16'h0000);
    chk("R1 status write no irq", {15'd0, irq_o}, 16'h0000);
    rd(8'h10);
    chk("R1 unmapped reads zero", rdata_o, 16'h0000);

    done = 1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule